// File: doc/BRIEF.md
# ROM Image Checksum and Socket Presence Scanner

This engine walks a row of byte-wide ROM sockets through a synchronous read port and judges each one in ascending socket order. For every socket it reads the header first. A socket whose tag byte and its partner byte are not bitwise complements is counted as empty and skipped without further reads. A populated socket must carry its own socket number in the header, or it is reported as sitting in the wrong place. A populated socket in the right place then has a 16-bit rotate-and-add checksum formed over its image and compared against the value stored in its first two bytes.

The scan stops at the first socket that is misplaced or fails its checksum, and reports which socket failed as a one-based code. If every socket passes or is empty, the scanner reports a pass and the number of empty sockets. A single start pulse launches a scan. Results are held with a done flag until the next start.

Top module: `romchk_scanner`

## Requirements
- R1: After reset, busy, done, pass, bad, misplaced, rd_en, fail_code and empty_cnt are all zero.
- R2: The read address is {socket index, byte offset}, with the socket index in the upper SOCK_W bits and the offset in the lower OFF_W bits. rd_data is taken as the byte for the address presented in the previous cycle with rd_en high. rd_en is only high while busy.
- R3: A socket is empty when the byte at offset 5 is not the bitwise complement of the byte at offset 4. Its ROM number and checksum are then ignored, it never causes a failure, and only offsets 0 to 5 of it are read.
- R4: A present socket whose byte at offset 2 differs from its socket index ends the scan with misplaced=1 and bad=0. The checksum is not computed.
- R5: For a present, correctly placed socket, acc starts at 0 and, for offsets 2 through 2^OFF_W-1 in order, acc = rotate_left(acc,1) + byte (mod 2^16). A result that differs from {byte 0, byte 1} (byte 0 the high half) ends the scan with bad=1.
- R6: On a failure, fail_code equals the failing socket index plus one. On a pass it is 0.
- R7: Sockets are examined from 0 to NUM_SOCK-1, and no address of a socket above the failing one is read.
- R8: When every socket is good or empty, pass=1 and empty_cnt equals the number of empty sockets.
- R9: done rises exactly T clock edges after the edge that samples start. T is the sum over the examined sockets of 7 for an empty or misplaced socket and 2^OFF_W+2 for a socket whose checksum is computed. busy and done are never high together.
- R10: A start pulse while busy has no effect on the result or its timing. While done is high with no start, all results hold. A start while idle clears done at the edge that samples it.
- R11: While done is high, exactly one of pass, bad and misplaced is 1. While done is low, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a scan when idle |
| rd_en | output | 1 | Read request for rd_addr |
| rd_addr | output | SOCK_W+OFF_W | {socket index, byte offset} |
| rd_data | input | 8 | Byte returned one cycle after the request |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Results valid, held until next start |
| pass | output | 1 | All sockets good or empty |
| bad | output | 1 | Checksum mismatch ended the scan |
| misplaced | output | 1 | ROM number mismatch ended the scan |
| fail_code | output | CNT_W | Failing socket index plus one, 0 on pass |
| empty_cnt | output | CNT_W | Empty sockets seen |

## Verification
With the default 64-byte images, an empty or misplaced socket takes 7 edges and a fully summed socket takes 66 edges. done is therefore due at a cycle count that the bench computes from the socket kinds it loaded. The bench counts edges from the one that samples start and samples all outputs on falling edges. It compares the count at which done first appears with that computed value, and only then reads the status. It also confirms that done was cleared on the falling edge right after the start edge, and that the results still hold five cycles after done.

// File: rtl/romchk_pkg.sv
// Shared constants, state type and checksum step for the ROM scanner.
package romchk_pkg;
    localparam int BYTE_W     = 8;
    localparam int SUM_W      = 16;
    localparam int OFF_SUM_HI = 0;
    localparam int OFF_SUM_LO = 1;
    localparam int OFF_NUM    = 2;
    localparam int OFF_TAG    = 4;
    localparam int OFF_TAG_N  = 5;
    localparam int OFF_FIRST  = 2;   // first byte included in the sum

    typedef enum logic [1:0] {ST_IDLE, ST_HEAD, ST_BODY} scan_st_t;

    // One rotate-left-by-one-then-add step of the running checksum.
    function automatic logic [SUM_W-1:0] spiral_step(input logic [SUM_W-1:0] acc,
                                                    input logic [BYTE_W-1:0] b);
        return {acc[SUM_W-2:0], acc[SUM_W-1]} + SUM_W'(b);
    endfunction
endpackage

// File: rtl/romchk_sum.sv
// Running checksum accumulator. Clears on clr (priority), steps on en.
// Assumes the byte presented on data_in is valid whenever en is high.
module romchk_sum
    import romchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [BYTE_W-1:0] data_in,
    output logic [SUM_W-1:0]  acc_nxt
);
    logic [SUM_W-1:0] acc_q;

    // Next value including the byte arriving this cycle.
    always_comb acc_nxt = spiral_step(acc_q, data_in);

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc_q <= '0;
        else if (clr) acc_q <= '0;
        else if (en)  acc_q <= acc_nxt;
    end
endmodule

// File: rtl/romchk_hdr.sv
// Captures header fields (stored checksum, ROM number, tag byte) as they
// stream past. Assumes off_in tags data_in whenever vld is high.
module romchk_hdr
    import romchk_pkg::*;
#(
    parameter int OFF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic [OFF_W-1:0]  off_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [SUM_W-1:0]  ref_sum,
    output logic [BYTE_W-1:0] rom_num,
    output logic [BYTE_W-1:0] tag
);
    // Latch each header byte at its offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_sum <= '0;
            rom_num <= '0;
            tag     <= '0;
        end else if (vld) begin
            if (off_in == OFF_W'(OFF_SUM_HI)) ref_sum[SUM_W-1:BYTE_W] <= data_in;
            if (off_in == OFF_W'(OFF_SUM_LO)) ref_sum[BYTE_W-1:0]     <= data_in;
            if (off_in == OFF_W'(OFF_NUM))    rom_num                 <= data_in;
            if (off_in == OFF_W'(OFF_TAG))    tag                     <= data_in;
        end
    end
endmodule

// File: rtl/romchk_ctrl.sv
// Scan sequencer: issues reads, tracks the one-cycle read latency, makes
// the per-socket presence / placement / checksum decisions and holds the
// results. Assumes OFF_W >= 3 and NUM_SOCK <= 2**SOCK_W.
module romchk_ctrl
    import romchk_pkg::*;
#(
    parameter int NUM_SOCK = 18,
    parameter int OFF_W    = 6,
    parameter int SOCK_W   = 5,
    parameter int CNT_W    = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [BYTE_W-1:0]       rd_data,
    input  logic [SUM_W-1:0]        sum_nxt,
    input  logic [SUM_W-1:0]        ref_sum,
    input  logic [BYTE_W-1:0]       rom_num,
    input  logic [BYTE_W-1:0]       tag,
    output logic                    rd_en,
    output logic [SOCK_W+OFF_W-1:0] rd_addr,
    output logic                    dat_vld,
    output logic [OFF_W-1:0]        dat_off,
    output logic                    sum_clr,
    output logic                    sum_en,
    output logic                    busy,
    output logic                    done,
    output logic                    pass,
    output logic                    bad,
    output logic                    misplaced,
    output logic [CNT_W-1:0]        fail_code,
    output logic [CNT_W-1:0]        empty_cnt
);
    scan_st_t            st_q;
    logic [SOCK_W-1:0]   sock_q;
    logic                iss_act_q;
    logic [OFF_W-1:0]    iss_off_q;
    logic                go, hdr_last, body_last, present, last_sock;
    logic                adv, enter_body, fin_pass, fin_bad, fin_mis, is_empty;

    assign rd_en   = iss_act_q;
    assign rd_addr = {sock_q, iss_off_q};
    assign busy    = (st_q != ST_IDLE);

    // Per-cycle decisions taken on the byte arriving this cycle.
    always_comb begin
        go         = (st_q == ST_IDLE) && start;
        hdr_last   = (st_q == ST_HEAD) && dat_vld && (dat_off == OFF_W'(OFF_TAG_N));
        body_last  = (st_q == ST_BODY) && dat_vld && (dat_off == '1);
        present    = (rd_data == ~tag);
        last_sock  = (sock_q == SOCK_W'(NUM_SOCK - 1));
        is_empty   = hdr_last && !present;
        fin_mis    = hdr_last && present && (rom_num != BYTE_W'(sock_q));
        enter_body = hdr_last && present && (rom_num == BYTE_W'(sock_q));
        fin_bad    = body_last && (sum_nxt != ref_sum);
        adv        = (is_empty || (body_last && !fin_bad)) && !last_sock;
        fin_pass   = (is_empty || (body_last && !fin_bad)) && last_sock;
        sum_en     = dat_vld && (dat_off >= OFF_W'(OFF_FIRST));
        sum_clr    = go || adv;
    end

    // Read pipeline, socket stepping and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;  sock_q <= '0;  iss_act_q <= 1'b0;  iss_off_q <= '0;
            dat_vld <= 1'b0;  dat_off <= '0; done <= 1'b0;       pass <= 1'b0;
            bad <= 1'b0;      misplaced <= 1'b0;  fail_code <= '0;  empty_cnt <= '0;
        end else begin
            dat_vld <= iss_act_q;
            dat_off <= iss_off_q;
            if (iss_act_q) begin
                iss_off_q <= iss_off_q + 1'b1;
                if ((st_q == ST_HEAD && iss_off_q == OFF_W'(OFF_TAG_N)) || iss_off_q == '1)
                    iss_act_q <= 1'b0;
            end
            if (go) begin
                st_q <= ST_HEAD;  sock_q <= '0;  iss_act_q <= 1'b1;  iss_off_q <= '0;
                done <= 1'b0;  pass <= 1'b0;  bad <= 1'b0;  misplaced <= 1'b0;
                fail_code <= '0;  empty_cnt <= '0;
            end
            if (is_empty)   empty_cnt <= empty_cnt + 1'b1;
            if (enter_body) begin
                st_q      <= ST_BODY;
                iss_act_q <= 1'b1;
            end
            if (adv) begin
                st_q      <= ST_HEAD;
                sock_q    <= sock_q + 1'b1;
                iss_act_q <= 1'b1;
                iss_off_q <= '0;
            end
            if (fin_pass || fin_bad || fin_mis) begin
                st_q      <= ST_IDLE;
                iss_act_q <= 1'b0;
                done      <= 1'b1;
                pass      <= fin_pass;
                bad       <= fin_bad;
                misplaced <= fin_mis;
                fail_code <= fin_pass ? '0 : CNT_W'(sock_q) + 1'b1;
            end
        end
    end
endmodule

// File: rtl/romchk_scanner.sv
// Top of the ROM scanner: sequencer, header capture and checksum unit.
// Assumes the read port returns data one cycle after rd_en/rd_addr.
module romchk_scanner
    import romchk_pkg::*;
#(
    parameter int NUM_SOCK = 18,
    parameter int OFF_W    = 6,
    localparam int SOCK_W  = $clog2(NUM_SOCK),
    localparam int ADDR_W  = SOCK_W + OFF_W,
    localparam int CNT_W   = $clog2(NUM_SOCK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              bad,
    output logic              misplaced,
    output logic [CNT_W-1:0]  fail_code,
    output logic [CNT_W-1:0]  empty_cnt
);
    logic              dat_vld, sum_clr, sum_en;
    logic [OFF_W-1:0]  dat_off;
    logic [SUM_W-1:0]  sum_nxt, ref_sum;
    logic [BYTE_W-1:0] rom_num, tag;

    romchk_ctrl #(.NUM_SOCK(NUM_SOCK), .OFF_W(OFF_W), .SOCK_W(SOCK_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_data(rd_data),
        .sum_nxt(sum_nxt), .ref_sum(ref_sum), .rom_num(rom_num), .tag(tag),
        .rd_en(rd_en), .rd_addr(rd_addr), .dat_vld(dat_vld), .dat_off(dat_off),
        .sum_clr(sum_clr), .sum_en(sum_en), .busy(busy), .done(done), .pass(pass),
        .bad(bad), .misplaced(misplaced), .fail_code(fail_code), .empty_cnt(empty_cnt)
    );

    romchk_hdr #(.OFF_W(OFF_W)) u_hdr (
        .clk(clk), .rst_n(rst_n), .vld(dat_vld), .off_in(dat_off), .data_in(rd_data),
        .ref_sum(ref_sum), .rom_num(rom_num), .tag(tag)
    );

    romchk_sum u_sum (
        .clk(clk), .rst_n(rst_n), .clr(sum_clr), .en(sum_en), .data_in(rd_data),
        .acc_nxt(sum_nxt)
    );
endmodule

// File: rtl/romchk_scanner_chk.sv
// Property checker for romchk_scanner, attached with bind below.
module romchk_scanner_chk #(
    parameter int NUM_SOCK = 18,
    parameter int OFF_W    = 6,
    parameter int ADDR_W   = 11,
    parameter int CNT_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              bad,
    input logic              misplaced,
    input logic [CNT_W-1:0]  fail_code,
    input logic [CNT_W-1:0]  empty_cnt
);
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({pass, bad, misplaced}) == 1)); // R11
    AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ({pass, bad, misplaced} == 3'b000)); // R11
    AST_READ_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy); // R2
    AST_SOCK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (32'(rd_addr[ADDR_W-1:OFF_W]) < NUM_SOCK)); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(fail_code) && $stable(empty_cnt))); // R10
    AST_PASS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (fail_code == '0)); // R6
    AST_FAIL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> (fail_code != '0 && 32'(fail_code) <= NUM_SOCK)); // R6
    AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R9
endmodule

bind romchk_scanner romchk_scanner_chk #(
    .NUM_SOCK(NUM_SOCK), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .busy(busy), .done(done), .pass(pass), .bad(bad), .misplaced(misplaced),
    .fail_code(fail_code), .empty_cnt(empty_cnt)
);

// File: tb/romchk_scanner_test.sv
module romchk_scanner_test;
    localparam int NS = 18, OW = 6, AW = 11, CW = 5, RB = 64;
    localparam int K_GOOD = 0, K_EMPTY = 1, K_MIS = 2, K_BAD = 3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic rd_en, busy, done, pass, bad, misplaced;
    logic [AW-1:0] rd_addr;
    logic [7:0] rd_data;
    logic [CW-1:0] fail_code, empty_cnt;
    logic [7:0] mem [0:(1<<AW)-1];
    int kinds [NS];
    int checks = 0, errors = 0;
    logic mon_clr = 1'b0;
    int max_sock;

    romchk_scanner #(.NUM_SOCK(NS), .OFF_W(OW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .done(done), .pass(pass), .bad(bad),
        .misplaced(misplaced), .fail_code(fail_code), .empty_cnt(empty_cnt)
    );

    always #5 clk = ~clk;

    // Read port model: one cycle latency.
    always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    // Highest socket addressed during a scan.
    always_ff @(posedge clk)
        if (mon_clr) max_sock <= -1;
        else if (rd_en && int'(rd_addr[AW-1:OW]) > max_sock) max_sock <= int'(rd_addr[AW-1:OW]);

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] spiral(int s);
        logic [15:0] a = '0;
        for (int o = 2; o < RB; o++) a = {a[14:0], a[15]} + 16'(mem[s*RB+o]);
        return a;
    endfunction

    task automatic build(int s, int num, bit present, bit corrupt);
        logic [15:0] sm;
        logic [7:0] tg;
        for (int o = 0; o < RB; o++) mem[s*RB+o] = 8'(s*37 + o*11 + 5);
        tg = 8'(8'h50 + s);
        mem[s*RB+2] = 8'(num);
        mem[s*RB+4] = tg;
        mem[s*RB+5] = present ? ~tg : tg;
        sm = spiral(s);
        mem[s*RB+0] = sm[15:8];
        mem[s*RB+1] = sm[7:0];
        if (corrupt) mem[s*RB+RB-1] = mem[s*RB+RB-1] ^ 8'h01;
    endtask

    task automatic load();
        for (int s = 0; s < NS; s++)
            case (kinds[s])
                K_EMPTY: build(s, s + 7, 1'b0, 1'b1);
                K_MIS:   build(s, s ^ 1, 1'b1, 1'b0);
                K_BAD:   build(s, s, 1'b1, 1'b1);
                default: build(s, s, 1'b1, 1'b0);
            endcase
    endtask

    task automatic set_all(int k);
        for (int s = 0; s < NS; s++) kinds[s] = k;
    endtask

    // Runs a scan and checks every result against values derived from kinds.
    task automatic run_check(string name, int restart_at);
        int lat = 0, emp = 0, code = 0, mx = -1, cyc = 0;
        bit e_pass = 1, e_bad = 0, e_mis = 0;
        int code_hold;
        for (int s = 0; s < NS; s++) begin
            mx = s;
            if (kinds[s] == K_EMPTY) begin lat += 7; emp++; end
            else if (kinds[s] == K_GOOD) lat += RB + 2;
            else if (kinds[s] == K_MIS) begin lat += 7; e_mis = 1; e_pass = 0; code = s + 1; break; end
            else begin lat += RB + 2; e_bad = 1; e_pass = 0; code = s + 1; break; end
        end
        load();
        mon_clr = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; mon_clr = 1'b0;
        chk("R10", {name, " done cleared by start"}, int'(done), 0);
        chk("R10", {name, " busy after start"}, int'(busy), 1);
        while (!done && cyc < 5000) begin
            @(negedge clk); cyc++;
            start = (cyc == restart_at);
        end
        start = 1'b0;
        if (!done) begin
            errors++; checks++;
            $display("FAIL R9 %s watchdog: actual %0d expected %0d", name, cyc, lat);
            return;
        end
        chk("R9", {name, " latency"}, cyc, lat);
        chk("R8", {name, " pass"}, int'(pass), int'(e_pass));
        chk("R5", {name, " bad"}, int'(bad), int'(e_bad));
        chk("R4", {name, " misplaced"}, int'(misplaced), int'(e_mis));
        chk("R6", {name, " fail_code"}, int'(fail_code), code);
        if (e_pass) chk("R8", {name, " empty_cnt"}, int'(empty_cnt), emp);
        chk("R7", {name, " highest socket read"}, max_sock, mx);
        code_hold = int'(fail_code);
        repeat (5) @(negedge clk);
        chk("R10", {name, " done held"}, int'(done), 1);
        chk("R10", {name, " code held"}, int'(fail_code), code_hold);
    endtask

    task automatic t_reset();
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "rd_en", int'(rd_en), 0);
        chk("R1", "flags", int'({pass, bad, misplaced}), 0);
        chk("R1", "fail_code", int'(fail_code), 0);
        chk("R1", "empty_cnt", int'(empty_cnt), 0);
    endtask

    task automatic t_all_good();   set_all(K_GOOD); run_check("R5 all good", 0); endtask
    task automatic t_empties();    // R3: empty sockets carry wrong number and sum
        set_all(K_GOOD); kinds[0] = K_EMPTY; kinds[3] = K_EMPTY; kinds[17] = K_EMPTY;
        run_check("R3 three empty", 0);
    endtask
    task automatic t_all_empty();  set_all(K_EMPTY); run_check("R3 all empty", 0); endtask
    task automatic t_misplaced();
        set_all(K_GOOD); kinds[2] = K_EMPTY; kinds[5] = K_MIS;
        run_check("R4 misplaced 5", 0);
    endtask
    task automatic t_bad_first();  set_all(K_GOOD); kinds[0] = K_BAD; run_check("R6 bad 0", 0); endtask
    task automatic t_bad_last();
        set_all(K_GOOD); kinds[4] = K_EMPTY; kinds[17] = K_BAD;
        run_check("R6 bad last", 0);
    endtask
    task automatic t_first_wins();
        set_all(K_GOOD); kinds[9] = K_BAD; kinds[12] = K_MIS;
        run_check("R7 first failure wins", 0);
    endtask
    task automatic t_busy_start(); set_all(K_GOOD); run_check("R10 start while busy", 100); endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_good();
        t_empties();
        t_all_empty();
        t_misplaced();
        t_bad_first();
        t_bad_last();
        t_first_wins();
        t_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule